// File: doc/BRIEF.md
# Dual-Latency Integer ALU with Early Result Path

This block is the integer ALU of one execution lane. Every cycle it may accept one operation: a 4-bit opcode and two 64-bit operands, qualified by a valid strobe. Every accepted operation produces a result through the regular two-stage path. That path is registered twice, so the result appears two clock edges after the operation is accepted.

Alongside the regular path there is a narrow one-stage path. It covers three groups:

- the bitwise logic operations;
- the 32-bit word add and subtract;
- full-width add and subtract when both operands sit well inside the signed 32-bit range.

When an operation falls in one of these groups, the early path registers its result after a single edge and raises a flag. The pipeline can then forward the value one cycle sooner.

The early path never replaces the regular one. The regular result for the same operation still arrives on the following cycle, and the two values are identical. The early path is built only in the lane whose index parameter is 1. In every other lane the early flag stays low.

Top module: `dual_lat_alu`

## Requirements
- R1: After reset is applied, `fast_valid` and `slow_valid` are both low.
- R2: An operation accepted with `in_valid` high at clock edge k gives `slow_valid` high and `slow_res` after edge k+1. `slow_valid` is low two edges after any edge where `in_valid` was low.
- R3: The opcode encoding and its `slow_res` result are:
  - 0: a+b
  - 1: a-b
  - 6: a AND b
  - 7: a OR b
  - 8: a XOR b
  - 9: logical left shift of a by b[5:0]
  - 10: logical right shift of a by b[5:0]
  - 11: arithmetic right shift of a by b[5:0]
  - 12: signed less-than, giving 1 or 0
  - 13: unsigned less-than, giving 1 or 0
  - 14 and 15: zero
- R4: The word operations use only the low 32 bits of the operands:
  - 2: a+b, with bit 31 copied into bits 63..32
  - 3: a+b, with bits 63..32 cleared
  - 4: a-b, with bit 31 copied into bits 63..32
  - 5: a-b, with bits 63..32 cleared
- R5: Word operations 2 to 5 always take the early path.
- R6: Full-width add and subtract (opcodes 0 and 1) take the early path exactly when bits 63..30 of each operand are all equal, whether all zeros or all ones.
- R7: Logic operations (opcodes 6 to 8) take the early path for any 64-bit operand values.
- R8: Opcodes 9 to 15 never take the early path.
- R9: For an operation that takes the early path, `fast_valid` is high and `fast_res` holds the result after edge k. `slow_res` on the next cycle equals that value.
- R10: `fast_valid` is low after any edge where `in_valid` was low.
- R11: An instance whose `LANE_ID` is not 1 never raises `fast_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Opcode |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand / shift amount |
| fast_valid | output | 1 | Early result valid |
| fast_res | output | 64 | Early result (one stage) |
| slow_valid | output | 1 | Regular result valid |
| slow_res | output | 64 | Regular result (two stages) |

## Verification
The embedded assertions check the following on every cycle:

- an early result is always matched by an equal regular result one cycle later;
- the early flag only ever follows a valid operation from the eligible opcode groups;
- the regular valid tracks the input valid with a two-cycle delay.

Only the directed scenarios can show the remaining behaviour: which operand values sit on each side of the ±2^30 boundary for full-width add and subtract, the exact word-extension results, and that a lane other than 1 stays silent.

// File: rtl/dual_lat_alu_pkg.sv
package dual_lat_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDWS = 4'd2,
    OP_ADDWU = 4'd3,
    OP_SUBWS = 4'd4,
    OP_SUBWU = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_SLL   = 4'd9,
    OP_SRL   = 4'd10,
    OP_SRA   = 4'd11,
    OP_SLT   = 4'd12,
    OP_SLTU  = 4'd13
  } alu_op_e;

  // Opcode groups that may use the one-stage path (operand range aside).
  function automatic logic op_fast_class(input logic [3:0] op);
    return (op <= 4'd8);
  endfunction
endpackage

// File: rtl/dual_lat_alu_slow.sv
module dual_lat_alu_slow #(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_res
);
  import dual_lat_alu_pkg::*;
  localparam int SHW = $clog2(XLEN);
  localparam int EXT = XLEN - WORD;

  logic            s1_valid;
  logic [3:0]      s1_op;
  logic [XLEN-1:0] s1_a, s1_b;
  logic [XLEN-1:0] res_nxt;
  logic [WORD-1:0] wsum, wdif;
  logic [SHW-1:0]  sh;

  // Stage 1: operand capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op <= in_op;
        s1_a  <= in_a;
        s1_b  <= in_b;
      end
    end
  end

  // Stage 2: full-width compute
  always_comb begin
    wsum = s1_a[WORD-1:0] + s1_b[WORD-1:0];
    wdif = s1_a[WORD-1:0] - s1_b[WORD-1:0];
    sh   = s1_b[SHW-1:0];
    case (s1_op)
      OP_ADD:   res_nxt = s1_a + s1_b;
      OP_SUB:   res_nxt = s1_a - s1_b;
      OP_ADDWS: res_nxt = {{EXT{wsum[WORD-1]}}, wsum};
      OP_ADDWU: res_nxt = {{EXT{1'b0}}, wsum};
      OP_SUBWS: res_nxt = {{EXT{wdif[WORD-1]}}, wdif};
      OP_SUBWU: res_nxt = {{EXT{1'b0}}, wdif};
      OP_AND:   res_nxt = s1_a & s1_b;
      OP_OR:    res_nxt = s1_a | s1_b;
      OP_XOR:   res_nxt = s1_a ^ s1_b;
      OP_SLL:   res_nxt = s1_a << sh;
      OP_SRL:   res_nxt = s1_a >> sh;
      OP_SRA:   res_nxt = $signed(s1_a) >>> sh;
      OP_SLT:   res_nxt = {{(XLEN-1){1'b0}}, $signed(s1_a) < $signed(s1_b)};
      OP_SLTU:  res_nxt = {{(XLEN-1){1'b0}}, s1_a < s1_b};
      default:  res_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_res <= res_nxt;
    end
  end

  // R2: regular result valid follows the input valid by two edges
  assert_slow_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  assert_slow_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
endmodule

// File: rtl/dual_lat_alu_qual.sv
module dual_lat_alu_qual #(
  parameter int XLEN  = 64,
  parameter int GUARD = 30
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            qualify
);
  import dual_lat_alu_pkg::*;
  localparam int GW = XLEN - GUARD;

  logic a_small, b_small;

  // Upper bits uniform: operand lies in [-2^GUARD, 2^GUARD)
  assign a_small = (a[XLEN-1:GUARD] == '0) || (a[XLEN-1:GUARD] == {GW{1'b1}});
  assign b_small = (b[XLEN-1:GUARD] == '0) || (b[XLEN-1:GUARD] == {GW{1'b1}});

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                        qualify = a_small && b_small;
      OP_ADDWS, OP_ADDWU, OP_SUBWS, OP_SUBWU: qualify = 1'b1;
      OP_AND, OP_OR, OP_XOR:                 qualify = 1'b1;
      default:                               qualify = 1'b0;
    endcase
  end
endmodule

// File: rtl/dual_lat_alu_fast.sv
module dual_lat_alu_fast #(
  parameter int XLEN  = 64,
  parameter int WORD  = 32,
  parameter int GUARD = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_res
);
  import dual_lat_alu_pkg::*;
  localparam int EXT = XLEN - WORD;

  logic            qual, take;
  logic [WORD-1:0] lsum, ldif;
  logic [XLEN-1:0] res_nxt;

  dual_lat_alu_qual #(.XLEN(XLEN), .GUARD(GUARD)) u_qual (
    .op(in_op), .a(in_a), .b(in_b), .qualify(qual)
  );

  assign take = in_valid && qual;

  // Narrow adder only: full-width add/sub reach here only in guarded range
  always_comb begin
    lsum = in_a[WORD-1:0] + in_b[WORD-1:0];
    ldif = in_a[WORD-1:0] - in_b[WORD-1:0];
    case (in_op)
      OP_ADD, OP_ADDWS: res_nxt = {{EXT{lsum[WORD-1]}}, lsum};
      OP_SUB, OP_SUBWS: res_nxt = {{EXT{ldif[WORD-1]}}, ldif};
      OP_ADDWU:         res_nxt = {{EXT{1'b0}}, lsum};
      OP_SUBWU:         res_nxt = {{EXT{1'b0}}, ldif};
      OP_AND:           res_nxt = in_a & in_b;
      OP_OR:            res_nxt = in_a | in_b;
      OP_XOR:           res_nxt = in_a ^ in_b;
      default:          res_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= take;
      if (take) out_res <= res_nxt;
    end
  end

  // R10: no early result after an idle cycle
  assert_fast_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8: early flag only for eligible opcode groups
  assert_fast_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> op_fast_class($past(in_op)));
endmodule

// File: rtl/dual_lat_alu.sv
module dual_lat_alu #(
  parameter int LANE_ID = 1,
  parameter int XLEN    = 64,
  parameter int WORD    = 32,
  parameter int GUARD   = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            fast_valid,
  output logic [XLEN-1:0] fast_res,
  output logic            slow_valid,
  output logic [XLEN-1:0] slow_res
);
  localparam bit HAS_FAST = (LANE_ID == 1);

  dual_lat_alu_slow #(.XLEN(XLEN), .WORD(WORD)) u_slow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(slow_valid), .out_res(slow_res)
  );

  generate
    if (HAS_FAST) begin : g_fast
      dual_lat_alu_fast #(.XLEN(XLEN), .WORD(WORD), .GUARD(GUARD)) u_fast (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(fast_valid), .out_res(fast_res)
      );
    end else begin : g_nofast
      assign fast_valid = 1'b0;
      assign fast_res   = '0;
    end
  endgenerate

  // R9: early result always equals the regular result one cycle later
  assert_fast_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fast_valid) |-> (slow_valid && slow_res == $past(fast_res)));
endmodule

// File: tb/sim_dual_lat_alu.sv
module sim_dual_lat_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [63:0] in_a, in_b;
  logic        fv0, sv0, fv1, sv1;
  logic [63:0] fr0, sr0, fr1, sr1;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dual_lat_alu #(.LANE_ID(1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .fast_valid(fv0), .fast_res(fr0),
    .slow_valid(sv0), .slow_res(sr0));
  dual_lat_alu #(.LANE_ID(0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .fast_valid(fv1), .fast_res(fr1),
    .slow_valid(sv1), .slow_res(sr1));

  localparam int NV = 19;
  localparam logic [3:0] V_OP [NV] = '{
    4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd1, 4'd2, 4'd3, 4'd4,
    4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd11, 4'd13, 4'd12, 4'd14};
  localparam logic [63:0] V_A [NV] = '{
    64'd5, 64'h3FFF_FFFF, 64'h4000_0000, 64'hFFFF_FFFF_C000_0000,
    64'hFFFF_FFFF_BFFF_FFFF, 64'd3, 64'd1, 64'h7FFF_FFFF, 64'h7FFF_FFFF,
    64'h1234_0000_0000_0000, 64'h1234_0000_0000_0000, 64'hF0F0_F0F0_F0F0_F0F0,
    64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1,
    64'h8000_0000_0000_0000, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd9};
  localparam logic [63:0] V_B [NV] = '{
    64'd7, 64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd10,
    64'h8000_0000_0000_0000, 64'd1, 64'd1, 64'd1, 64'd1,
    64'hFF00_FF00_FF00_FF00, 64'd1, 64'h0123_4567_89AB_CDEF, 64'd40, 64'd4,
    64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd9};
  localparam bit V_FAST [NV] = '{
    1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a, b);
    logic [31:0] s, d;
    s = a[31:0] + b[31:0];
    d = a[31:0] - b[31:0];
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return {{32{s[31]}}, s};
      4'd3: return {32'd0, s};
      4'd4: return {{32{d[31]}}, d};
      4'd5: return {32'd0, d};
      4'd6: return a & b;
      4'd7: return a | b;
      4'd8: return a ^ b;
      4'd9: return a << b[5:0];
      4'd10: return a >> b[5:0];
      4'd11: return $signed(a) >>> b[5:0];
      4'd12: return {63'd0, $signed(a) < $signed(b)};
      4'd13: return {63'd0, a < b};
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One isolated operation; samples at negedges after each register stage
  task automatic run_one(input logic [3:0] op, input logic [63:0] a, b, input bit expf);
    logic [63:0] exp;
    exp = model(op, a, b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(fv0 == expf, "R5/R6/R7/R8 fast flag", {63'd0, fv0}, {63'd0, expf});
    if (expf) check(fr0 == exp, "R9 fast result", fr0, exp);
    check(fv1 == 1'b0, "R11 other lane", {63'd0, fv1}, 64'd0);
    @(negedge clk);
    check(sv0 == 1'b1, "R2 slow valid", {63'd0, sv0}, 64'd1);
    check(sr0 == exp, (op inside {[4'd2:4'd5]}) ? "R4 word result" : "R3 slow result", sr0, exp);
    check(sr1 == exp, "R11 other lane slow", sr1, exp);
    check(fv0 == 1'b0, "R10 idle clears fast", {63'd0, fv0}, 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    check(!fv0 && !sv0, "R1 reset state", {62'd0, fv0, sv0}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_one(V_OP[i], V_A[i], V_B[i], V_FAST[i]);

    // R10: eligible op presented with in_valid low
    @(negedge clk);
    in_valid = 1'b0; in_op = 4'd6; in_a = '1; in_b = '1;
    @(negedge clk);
    check(fv0 == 1'b0, "R10 invalid AND no fast", {63'd0, fv0}, 64'd0);
    @(negedge clk);
    check(sv0 == 1'b0, "R2 invalid no slow", {63'd0, sv0}, 64'd0);

    // R9: back-to-back pipelined fast ops
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'd7; in_a = 64'hA; in_b = 64'h5;
    @(negedge clk);
    check(fv0 && fr0 == 64'hF, "R9 b2b first fast", fr0, 64'hF);
    in_op = 4'd1; in_a = 64'd2; in_b = 64'd5;
    @(negedge clk);
    in_valid = 1'b0;
    check(sr0 == 64'hF, "R9 b2b first slow", sr0, 64'hF);
    check(fv0 && fr0 == 64'hFFFF_FFFF_FFFF_FFFD, "R9 b2b second fast", fr0, 64'hFFFF_FFFF_FFFF_FFFD);
    @(negedge clk);
    check(sr0 == 64'hFFFF_FFFF_FFFF_FFFD, "R9 b2b second slow", sr0, 64'hFFFF_FFFF_FFFF_FFFD);

    // R1: reset mid-stream clears valids
    in_valid = 1'b1; in_op = 4'd0; in_a = 64'd1; in_b = 64'd1;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(!fv0 && !sv0, "R1 mid-run reset", {62'd0, fv0, sv0}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule